// File: doc/BRIEF.md
# Boot Table Loader Engine

This block is a post-reset copy engine. On a start pulse it performs one I/O read of a fixed mode word and derives from it the base of a boot table in slow external data memory. It then walks that table. A tag word picks 16-bit or byte-wide memory. Three configuration words go to wait-state and bank control outputs, and a two-word entry point is captured. After that, sections are copied into program memory one by one until a section of length zero. At the end the block raises `done` and presents the entry point that the processor should branch to.

Reads go through a request/valid port with one access in flight. On a byte-wide table every 16-bit item is put together from two successive byte reads. Until the table supplies its own wait-state word, the block asks the memory for the slowest access timing. A tag that matches neither width stops the walk and raises `error`.

Top module: `boot_table_loader`

## Requirements
- R1: After reset `done`, `error`, `busy`, `mem_req` and `pm_we` are 0 and `mem_wait` is 7.
- R2: A start pulse causes one read with `mem_io`=1 at address FFFFh. Bits 15:10 of the returned word become bits 15:10 of the table base, and the base's low ten bits are zero, so the word's bits 9:0 have no effect.
- R3: A first table word of 10AAh selects 16-bit mode. Each later item is one read, and the read address rises by one per read.
- R4: A first table word of 0008h followed by a word with low byte AAh selects byte mode. Each later item is two reads at successive addresses, the first giving bits 15:8 and the second bits 7:0, using bits 7:0 of the read data.
- R5: Any other tag sets `error`=1, leaves `done`=0 and writes nothing to program memory. `error` stays set until the next start.
- R6: The three items after the tag are driven, in that order, onto `cfg_wait`, `cfg_wctl` and `cfg_bank`.
- R7: `mem_wait` is 7 for every read up to and including the one that fetches the wait-state item. After that it equals that item's bits 2:0.
- R8: The next two items are the entry page and the entry address. When `done` rises, `entry` equals {page bits 6:0, address}.
- R9: Each section is a size, a destination page and a destination address, followed by size code words. These are written with `pm_we` to {page bits 6:0, address+i}, and the low 16 bits wrap while the page is unchanged.
- R10: A size item of 0000h ends the table. `done` becomes 1 and stays 1 until the next start.
- R11: While `mem_req` is high and `mem_rvalid` has not yet come, `mem_addr` and `mem_io` hold steady and `mem_req` stays high.
- R12: A start pulse during a load is ignored: the mode word is not read again and the outcome is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a load when the block is not busy |
| mem_req | output | 1 | Read request, held until `mem_rvalid` |
| mem_io | output | 1 | Request targets I/O space (mode word) |
| mem_addr | output | AW | Read address |
| mem_wait | output | WSW | Wait states the memory should apply |
| mem_rvalid | input | 1 | Read data valid, completes the request |
| mem_rdata | input | 16 | Read data |
| pm_we | output | 1 | Program-memory write strobe |
| pm_addr | output | XPW+16 | Program-memory write address {page, address} |
| pm_wdata | output | 16 | Program-memory write data |
| cfg_wait | output | 16 | Wait-state configuration item |
| cfg_wctl | output | 16 | Wait-state control item |
| cfg_bank | output | 16 | Bank control item |
| busy | output | 1 | Load in progress |
| done | output | 1 | Table finished; `entry` is valid |
| error | output | 1 | Bad tag word |
| entry | output | XPW+16 | Captured entry point |

## Verification
The bench uses the default widths: 16-bit data addresses, a 7-bit page field and a 3-bit wait field. Its memory model holds a 4K-word window, so it can place tables at bases whose mode words also carry junk low bits. Passes in both widths cover several section counts, including none. They also cover page words with bits above the 7-bit field, a destination that wraps past FFFFh, both bad-tag forms and a restart pulse during a copy. Read counts, wait values seen per request and every program-memory write are compared with values worked out from the table layout.

// File: rtl/bootld_pkg.sv
package bootld_pkg;
  localparam logic [15:0] TAG_WIDE    = 16'h10AA;
  localparam logic [15:0] TAG_BYTE_HI = 16'h0008;
  localparam logic [7:0]  TAG_BYTE_LO = 8'hAA;

  typedef enum logic [3:0] {
    S_IDLE, S_MODE, S_TAG, S_TAG2, S_CWAIT, S_CWCTL, S_CBANK,
    S_EPAGE, S_EADDR, S_SIZE, S_DPAGE, S_DADDR, S_COPY, S_DONE, S_ERR
  } ld_state_t;

  typedef enum logic [1:0] {
    F_IDLE, F_FIRST, F_SECOND
  } fetch_state_t;
endpackage

// File: rtl/bootld_fetch.sv
module bootld_fetch
  import bootld_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          single,
  input  logic          io,
  input  logic          byte_mode,
  input  logic          base_ld,
  input  logic [AW-1:0] base,
  output logic          mem_req,
  output logic          mem_io,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [15:0]   mem_rdata,
  output logic          wvalid,
  output logic [15:0]   wdata,
  output logic          fidle
);
  localparam logic [AW-1:0] IO_MODE_ADDR = '1;

  fetch_state_t fst;
  logic [AW-1:0] ptr;
  logic [7:0]    hi_byte;
  logic          pair;

  assign fidle = (fst == F_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      fst      <= F_IDLE;
      mem_req  <= 1'b0;
      mem_io   <= 1'b0;
      mem_addr <= '0;
      ptr      <= '0;
      hi_byte  <= '0;
      pair     <= 1'b0;
      wvalid   <= 1'b0;
      wdata    <= '0;
    end else begin
      wvalid <= 1'b0;
      case (fst)
        F_IDLE: begin
          if (go) begin
            mem_req  <= 1'b1;
            mem_io   <= io;
            mem_addr <= io ? IO_MODE_ADDR : ptr;
            pair     <= byte_mode && !single && !io;
            fst      <= F_FIRST;
          end
        end
        F_FIRST: begin
          if (mem_rvalid) begin
            if (!mem_io) ptr <= ptr + 1'b1;
            if (pair) begin
              hi_byte  <= mem_rdata[7:0];
              mem_addr <= ptr + 1'b1;
              fst      <= F_SECOND;
            end else begin
              mem_req <= 1'b0;
              wvalid  <= 1'b1;
              wdata   <= mem_rdata;
              fst     <= F_IDLE;
            end
          end
        end
        F_SECOND: begin
          if (mem_rvalid) begin
            ptr     <= ptr + 1'b1;
            mem_req <= 1'b0;
            wvalid  <= 1'b1;
            wdata   <= {hi_byte, mem_rdata[7:0]};
            fst     <= F_IDLE;
          end
        end
        default: fst <= F_IDLE;
      endcase
      if (base_ld) ptr <= base;
    end
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr) && $stable(mem_io)));
endmodule

// File: rtl/bootld_seq.sv
module bootld_seq
  import bootld_pkg::*;
#(
  parameter int AW      = 16,
  parameter int XPW     = 7,
  parameter int WSW     = 3,
  parameter int WS_INIT = 7,
  localparam int PAW    = XPW + 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           wvalid,
  input  logic [15:0]    wdata,
  input  logic           fidle,
  output logic           go,
  output logic           single,
  output logic           io,
  output logic           byte_mode,
  output logic           base_ld,
  output logic [AW-1:0]  base,
  output logic [WSW-1:0] mem_wait,
  output logic           pm_we,
  output logic [PAW-1:0] pm_addr,
  output logic [15:0]    pm_wdata,
  output logic [15:0]    cfg_wait,
  output logic [15:0]    cfg_wctl,
  output logic [15:0]    cfg_bank,
  output logic           busy,
  output logic           done,
  output logic           error,
  output logic [PAW-1:0] entry
);
  localparam int BASE_SHIFT = AW - 6;

  ld_state_t      st;
  logic           pend;
  logic [15:0]    remain;
  logic [XPW-1:0] dst_page;
  logic [15:0]    dst_addr;
  logic           wants_word;

  assign busy = (st != S_IDLE) && (st != S_DONE) && (st != S_ERR);
  assign wants_word = busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      pend      <= 1'b0;
      go        <= 1'b0;
      single    <= 1'b0;
      io        <= 1'b0;
      byte_mode <= 1'b0;
      base_ld   <= 1'b0;
      base      <= '0;
      mem_wait  <= WSW'(WS_INIT);
      pm_we     <= 1'b0;
      pm_addr   <= '0;
      pm_wdata  <= '0;
      cfg_wait  <= '0;
      cfg_wctl  <= '0;
      cfg_bank  <= '0;
      done      <= 1'b0;
      error     <= 1'b0;
      entry     <= '0;
      remain    <= '0;
      dst_page  <= '0;
      dst_addr  <= '0;
    end else begin
      go      <= 1'b0;
      base_ld <= 1'b0;
      pm_we   <= 1'b0;

      if (wants_word && !pend && fidle) begin
        go     <= 1'b1;
        pend   <= 1'b1;
        io     <= (st == S_MODE);
        single <= (st == S_MODE) || (st == S_TAG) || (st == S_TAG2);
      end

      if (!busy) begin
        if (start) begin
          st        <= S_MODE;
          pend      <= 1'b0;
          done      <= 1'b0;
          error     <= 1'b0;
          byte_mode <= 1'b0;
          mem_wait  <= WSW'(WS_INIT);
        end
      end else if (wvalid) begin
        pend <= 1'b0;
        case (st)
          S_MODE: begin
            base    <= AW'(wdata[15:10]) << BASE_SHIFT;
            base_ld <= 1'b1;
            st      <= S_TAG;
          end
          S_TAG: begin
            if (wdata == TAG_WIDE) begin
              byte_mode <= 1'b0;
              st        <= S_CWAIT;
            end else if (wdata == TAG_BYTE_HI) begin
              st <= S_TAG2;
            end else begin
              error <= 1'b1;
              st    <= S_ERR;
            end
          end
          S_TAG2: begin
            if (wdata[7:0] == TAG_BYTE_LO) begin
              byte_mode <= 1'b1;
              st        <= S_CWAIT;
            end else begin
              error <= 1'b1;
              st    <= S_ERR;
            end
          end
          S_CWAIT: begin
            cfg_wait <= wdata;
            mem_wait <= wdata[WSW-1:0];
            st       <= S_CWCTL;
          end
          S_CWCTL: begin
            cfg_wctl <= wdata;
            st       <= S_CBANK;
          end
          S_CBANK: begin
            cfg_bank <= wdata;
            st       <= S_EPAGE;
          end
          S_EPAGE: begin
            entry[PAW-1:16] <= wdata[XPW-1:0];
            st              <= S_EADDR;
          end
          S_EADDR: begin
            entry[15:0] <= wdata;
            st          <= S_SIZE;
          end
          S_SIZE: begin
            if (wdata == 16'h0000) begin
              done <= 1'b1;
              st   <= S_DONE;
            end else begin
              remain <= wdata;
              st     <= S_DPAGE;
            end
          end
          S_DPAGE: begin
            dst_page <= wdata[XPW-1:0];
            st       <= S_DADDR;
          end
          S_DADDR: begin
            dst_addr <= wdata;
            st       <= S_COPY;
          end
          S_COPY: begin
            pm_we    <= 1'b1;
            pm_addr  <= {dst_page, dst_addr};
            pm_wdata <= wdata;
            dst_addr <= dst_addr + 16'd1;
            remain   <= remain - 16'd1;
            if (remain == 16'd1) st <= S_SIZE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R5
  err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    error |-> !done);

  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (error && !start) |=> error);

  // R8
  entry_stable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $stable(entry));

  // R12
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start && st != S_MODE) |=> (st != S_MODE));

  // R9
  we_in_load_chk: assert property (@(posedge clk) disable iff (rst)
    pm_we |-> (busy && !done && !error));
endmodule

// File: rtl/boot_table_loader.sv
module boot_table_loader
  import bootld_pkg::*;
#(
  parameter int AW      = 16,
  parameter int XPW     = 7,
  parameter int WSW     = 3,
  parameter int WS_INIT = 7,
  localparam int PAW    = XPW + 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  output logic           mem_req,
  output logic           mem_io,
  output logic [AW-1:0]  mem_addr,
  output logic [WSW-1:0] mem_wait,
  input  logic           mem_rvalid,
  input  logic [15:0]    mem_rdata,
  output logic           pm_we,
  output logic [PAW-1:0] pm_addr,
  output logic [15:0]    pm_wdata,
  output logic [15:0]    cfg_wait,
  output logic [15:0]    cfg_wctl,
  output logic [15:0]    cfg_bank,
  output logic           busy,
  output logic           done,
  output logic           error,
  output logic [PAW-1:0] entry
);
  logic          go, single, io, byte_mode, base_ld, wvalid, fidle;
  logic [AW-1:0] base;
  logic [15:0]   wdata;

  bootld_fetch #(.AW(AW)) u_fetch (
    .clk(clk), .rst(rst), .go(go), .single(single), .io(io),
    .byte_mode(byte_mode), .base_ld(base_ld), .base(base),
    .mem_req(mem_req), .mem_io(mem_io), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .wvalid(wvalid), .wdata(wdata), .fidle(fidle)
  );

  bootld_seq #(.AW(AW), .XPW(XPW), .WSW(WSW), .WS_INIT(WS_INIT)) u_seq (
    .clk(clk), .rst(rst), .start(start), .wvalid(wvalid), .wdata(wdata),
    .fidle(fidle), .go(go), .single(single), .io(io), .byte_mode(byte_mode),
    .base_ld(base_ld), .base(base), .mem_wait(mem_wait),
    .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata),
    .cfg_wait(cfg_wait), .cfg_wctl(cfg_wctl), .cfg_bank(cfg_bank),
    .busy(busy), .done(done), .error(error), .entry(entry)
  );

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_req && !pm_we));
endmodule

// File: tb/boot_table_loader_test.sv
module boot_table_loader_test;
  localparam int CLK_PERIOD = 10;
  localparam int PAW = 23;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic mem_req, mem_io, mem_rvalid;
  logic [15:0] mem_addr, mem_rdata;
  logic [2:0] mem_wait;
  logic pm_we, busy, done, error;
  logic [PAW-1:0] pm_addr, entry;
  logic [15:0] pm_wdata, cfg_wait, cfg_wctl, cfg_bank;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_table_loader uut (
    .clk(clk), .rst(rst), .start(start),
    .mem_req(mem_req), .mem_io(mem_io), .mem_addr(mem_addr), .mem_wait(mem_wait),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata),
    .cfg_wait(cfg_wait), .cfg_wctl(cfg_wctl), .cfg_bank(cfg_bank),
    .busy(busy), .done(done), .error(error), .entry(entry)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [15:0] img [0:4095];
  logic [15:0] io_word;
  logic [15:0] cur_base;
  logic [15:0] wsr_off;
  logic [2:0]  exp_wait;
  logic        mbusy;
  int          mcnt;
  logic [15:0] maddr_q;
  logic        mio_q;
  int io_reads, data_reads, hold_viol, wait_err, nlog;
  logic [15:0] off;
  logic [PAW-1:0] log_a [0:63];
  logic [15:0]    log_d [0:63];

  int          nsec;
  int          sec_sz [0:3];
  logic [15:0] sec_pg [0:3];
  logic [15:0] sec_ad [0:3];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // memory model with request/valid timing of mem_wait+1 cycles
  always @(posedge clk) begin
    if (rst) begin
      mem_rvalid <= 1'b0; mem_rdata <= '0; mbusy <= 1'b0; mcnt <= 0;
    end else begin
      mem_rvalid <= 1'b0;
      if (mbusy) begin
        if (mem_addr != maddr_q || mem_io != mio_q || !mem_req) hold_viol++;
        if (mcnt == 0) begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= mio_q ? io_word : img[maddr_q[11:0]];
          mbusy      <= 1'b0;
        end else mcnt <= mcnt - 1;
      end else if (mem_req && !mem_rvalid) begin
        mbusy <= 1'b1; mcnt <= int'(mem_wait); maddr_q <= mem_addr; mio_q <= mem_io;
        if (mem_io) begin
          io_reads++;
          if (mem_addr != 16'hFFFF) hold_viol++;
        end else data_reads++;
        off = mem_addr - cur_base;
        if (mem_io || off <= wsr_off) begin
          if (mem_wait != 3'd7) wait_err++;
        end else if (mem_wait != exp_wait) wait_err++;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && pm_we && nlog < 64) begin
      log_a[nlog] = pm_addr; log_d[nlog] = pm_wdata; nlog++;
    end
  end

  function automatic logic [15:0] code_word(input int s, input int i);
    return {4'(s + 1), 12'(i * 37 + 5)};
  endfunction

  task automatic put(input bit bm, input int ofs, input logic [15:0] v);
    if (bm) begin
      img[12'(cur_base + 16'(2*ofs))]     = {8'h00, v[15:8]};
      img[12'(cur_base + 16'(2*ofs + 1))] = {8'h00, v[7:0]};
    end else img[12'(cur_base + 16'(ofs))] = v;
  endtask

  // builds table; returns item count after the tag
  task automatic build(input bit bm, input logic [15:0] w0, input logic [15:0] w1,
                       input logic [15:0] w2, input logic [15:0] epg,
                       input logic [15:0] ead, output int items);
    int k;
    for (int a = 0; a < 4096; a++) img[a] = 16'hDEAD;
    put(bm, 0, bm ? 16'h08AA : 16'h10AA);
    put(bm, 1, w0); put(bm, 2, w1); put(bm, 3, w2);
    put(bm, 4, epg); put(bm, 5, ead);
    k = 6;
    for (int s = 0; s < nsec; s++) begin
      put(bm, k, 16'(sec_sz[s])); put(bm, k+1, sec_pg[s]); put(bm, k+2, sec_ad[s]);
      k += 3;
      for (int i = 0; i < sec_sz[s]; i++) begin put(bm, k, code_word(s, i)); k++; end
    end
    put(bm, k, 16'h0000);
    items = k;
    wsr_off = bm ? 16'd3 : 16'd1;
    exp_wait = w0[2:0];
  endtask

  task automatic launch(input int restart_at);
    io_reads = 0; data_reads = 0; hold_viol = 0; wait_err = 0; nlog = 0;
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    for (int n = 0; n < 20000 && !done && !error; n++) begin
      @(negedge clk);
      if (n == restart_at) begin start = 1'b1; @(negedge clk); start = 1'b0; end
    end
  endtask

  task automatic check_good(input string t, input bit bm, input int items,
                            input logic [15:0] w0, input logic [15:0] w1, input logic [15:0] w2,
                            input logic [15:0] epg, input logic [15:0] ead);
    int idx, exp_reads;
    chk(done == 1'b1 && error == 1'b0, {t, " R10 done"}, {done, error}, 2'b10);
    chk(io_reads == 1, {t, " R2 R12 mode reads"}, io_reads, 1);
    exp_reads = bm ? 2 * (items + 1) : items + 1;
    chk(data_reads == exp_reads, {t, bm ? " R4 reads" : " R3 reads"}, data_reads, exp_reads);
    chk(hold_viol == 0, {t, " R11 hold"}, hold_viol, 0);
    chk(wait_err == 0, {t, " R7 wait"}, wait_err, 0);
    chk(cfg_wait == w0 && cfg_wctl == w1 && cfg_bank == w2, {t, " R6 cfg"},
        {cfg_wait, cfg_wctl}, {w0, w1});
    chk(entry == {epg[6:0], ead}, {t, " R8 entry"}, entry, {epg[6:0], ead});
    idx = 0;
    for (int s = 0; s < nsec; s++)
      for (int i = 0; i < sec_sz[s]; i++) begin
        chk(log_a[idx] == {sec_pg[s][6:0], 16'(sec_ad[s] + 16'(i))} && log_d[idx] == code_word(s, i),
            {t, " R9 write"}, {9'h0, log_a[idx]}, {9'h0, sec_pg[s][6:0], 16'(sec_ad[s] + 16'(i))});
        idx++;
      end
    chk(nlog == idx, {t, " R9 count"}, nlog, idx);
  endtask

  initial begin
    int items;
    for (int a = 0; a < 4096; a++) img[a] = 16'h0;
    io_word = 16'h0; cur_base = 16'h0; wsr_off = 16'h1; exp_wait = 3'd7;
    io_reads = 0; data_reads = 0; hold_viol = 0; wait_err = 0; nlog = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!done && !error && !busy && !mem_req && !pm_we, "R1 idle", {done, error, busy, mem_req, pm_we}, 0);
    chk(mem_wait == 3'd7, "R1 wait", mem_wait, 7);

    // T1: 16-bit table, junk low bits in mode word, restart pulse mid-load (R2 R3 R12)
    io_word = 16'hF3FF; cur_base = 16'hF000; nsec = 2;
    sec_sz[0] = 3; sec_pg[0] = 16'h0000; sec_ad[0] = 16'h0100;
    sec_sz[1] = 5; sec_pg[1] = 16'h0283; sec_ad[1] = 16'h0500;
    build(1'b0, 16'h0002, 16'h1230, 16'hB005, 16'h0001, 16'h0100, items);
    launch(40);
    check_good("T1", 1'b0, items, 16'h0002, 16'h1230, 16'hB005, 16'h0001, 16'h0100);
    repeat (5) @(negedge clk);
    chk(done == 1'b1, "T1 R10 done held", done, 1);

    // T2: byte table, destination wraps past FFFFh (R4 R9)
    io_word = 16'hE400; cur_base = 16'hE400; nsec = 3;
    sec_sz[0] = 4; sec_pg[0] = 16'h0003; sec_ad[0] = 16'h2000;
    sec_sz[1] = 1; sec_pg[1] = 16'h0000; sec_ad[1] = 16'h0040;
    sec_sz[2] = 3; sec_pg[2] = 16'h0005; sec_ad[2] = 16'hFFFE;
    build(1'b1, 16'h0001, 16'h5A5A, 16'h00C3, 16'h007F, 16'hBEEF, items);
    launch(-1);
    check_good("T2", 1'b1, items, 16'h0001, 16'h5A5A, 16'h00C3, 16'h007F, 16'hBEEF);

    // T3: bad 16-bit tag (R5)
    io_word = 16'hF000; cur_base = 16'hF000; nsec = 0;
    build(1'b0, 16'h0000, 16'h0, 16'h0, 16'h0, 16'h0, items);
    img[0] = 16'h1234;
    launch(-1);
    repeat (20) @(negedge clk);
    chk(error == 1'b1 && done == 1'b0, "T3 R5 error", {error, done}, 2'b10);
    chk(nlog == 0, "T3 R5 no writes", nlog, 0);

    // T4: byte tag with bad second byte (R5)
    img[0] = 16'h0008; img[1] = 16'h0055;
    launch(-1);
    chk(error == 1'b1 && done == 1'b0 && nlog == 0, "T4 R5 error", {error, done}, 2'b10);

    // T5: empty table after error, zero wait states (R10 R7)
    io_word = 16'hF000; cur_base = 16'hF000; nsec = 0;
    build(1'b0, 16'h0000, 16'hFFFF, 16'h0001, 16'h0040, 16'h8000, items);
    launch(-1);
    check_good("T5", 1'b0, items, 16'h0000, 16'hFFFF, 16'h0001, 16'h0040, 16'h8000);
    chk(mem_wait == 3'd0, "T5 R7 wait out", mem_wait, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule